// File: doc/BRIEF.md
# Execute-Qualified Instruction Breakpoint Unit

This block compares each instruction fetch address against a small bank of programmable address comparators. A hit at fetch time does not raise a halt straight away. It becomes a tag that moves with the instruction through a fixed two-stage pipeline. The debug-halt request is raised only when that instruction is actually executed. If a flush discards the tagged instruction, the tag is dropped and no halt occurs.

Software programs the comparators through a simple write port. Each comparator has its own enable bit and its own halfword address, and one global enable gates the whole bank. Matches are possible only inside the code region, byte addresses 0x0000_0000 to 0x1FFF_FFFF. A status record keeps the index of the comparator that caused the most recent halt. A parameter selects the full configuration with four comparators or the reduced configuration with two.

Top module: `bkpt_unit`

## Requirements
- R1: With `FULL_CFG`=1 the unit has four comparators (register indices 0..3). With `FULL_CFG`=0 it has two (indices 0..1), and writes to indices 2 and 3 have no effect.
- R2: A write with `cfg_addr` = k (k below the comparator count) programs comparator k. `cfg_wdata[0]` is its enable and `cfg_wdata[28:1]` is its halfword address. Each comparator is programmed and enabled without affecting the others.
- R3: A write with `cfg_addr` = 4 sets the global enable from `cfg_wdata[0]`. While the global enable is 0, no comparator can match.
- R4: A comparator matches a valid fetch when `fetch_addr[28:1]` equals its stored address and `fetch_addr[31:29]` is zero. Address bit 0 is ignored. A fetch outside the code region never matches.
- R5: A fetch hit in cycle T raises `halt_req` for exactly one cycle, T+3, and only if `exec_strobe` is high in cycle T+2. If `exec_strobe` is low in T+2, there is no halt.
- R6: `flush` high in cycle T, T+1 or T+2 of a fetch in cycle T cancels that instruction's halt.
- R7: When several enabled comparators match the same fetch, the lowest index is recorded as the cause.
- R8: A halt sets `stat_valid` and loads `stat_idx` with the causing comparator index in the same cycle as `halt_req`. A write with `cfg_addr` = 5 and `cfg_wdata[0]`=1 clears `stat_valid`. If a new halt and a clear arrive together, the halt wins.
- R9: After reset, `halt_req` and `stat_valid` are 0, and all comparators and the global enable are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0..3 comparators, 4 global enable, 5 status clear |
| cfg_wdata | input | 32 | Register write data |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Byte address of the fetched instruction |
| exec_strobe | input | 1 | Instruction in the execute stage is executed this cycle |
| flush | input | 1 | Discard every instruction in flight |
| halt_req | output | 1 | One-cycle debug-halt request |
| stat_valid | output | 1 | A breakpoint cause is recorded |
| stat_idx | output | 2 | Index of the comparator behind the last halt |

## Verification
The assertions assume that `exec_strobe` refers to the instruction that was fetched exactly two cycles earlier. They also assume that `flush`, `exec_strobe` and `fetch_valid` are never unknown once reset is released. The stimulus keeps to these assumptions by sending one instruction at a time through a fixed fetch, gap and execute sequence, and by driving every input to a defined value from time zero. Under these conditions, the latency and flush checks compare the pipeline against the intended timing rather than against overlapping traffic that the assumptions do not cover.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int MAX_CMP  = 4;
  localparam int IDX_W    = 2;
  localparam int CODE_MSB = 28;            // code region: addr[31:29] == 0
  localparam logic [2:0] REG_CTRL = 3'd4;  // global enable
  localparam logic [2:0] REG_STAT = 3'd5;  // status, write 1 to clear

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } bkpt_tag_t;

  function automatic int cmp_count(input bit full);
    return full ? MAX_CMP : MAX_CMP / 2;
  endfunction
endpackage

// File: rtl/bkpt_cmp_bank.sv
module bkpt_cmp_bank
  import bkpt_pkg::*;
#(
  parameter int NUM_CMP = 4,
  parameter int ADDR_W  = 32,
  parameter int CFG_AW  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [31:0]        cfg_wdata,
  input  logic               fetch_valid,
  input  logic [ADDR_W-1:0]  fetch_addr,
  output logic [NUM_CMP-1:0] match
);
  localparam int CMP_W = CODE_MSB;

  logic glob_en_q;
  logic in_code;
  logic unused_bits;

  assign in_code     = (fetch_addr[ADDR_W-1:CODE_MSB+1] == '0);
  assign unused_bits = ^{fetch_addr[0], cfg_wdata[31:CODE_MSB+1]};

  always_ff @(posedge clk) begin
    if (rst)
      glob_en_q <= 1'b0;
    else if (cfg_we && cfg_addr == CFG_AW'(REG_CTRL))
      glob_en_q <= cfg_wdata[0];
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    logic             en_q;
    logic [CMP_W-1:0] val_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q  <= 1'b0;
        val_q <= '0;
      end else if (cfg_we && cfg_addr == CFG_AW'(i)) begin
        en_q  <= cfg_wdata[0];
        val_q <= cfg_wdata[CODE_MSB:1];
      end
    end

    assign match[i] = fetch_valid & glob_en_q & in_code & en_q &
                      (fetch_addr[CODE_MSB:1] == val_q);
  end

  // R4
  code_region_chk: assert property (@(posedge clk) disable iff (rst)
    (|match) |-> (fetch_valid && fetch_addr[ADDR_W-1:CODE_MSB+1] == '0));

  // R3
  glob_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_we && cfg_addr == CFG_AW'(REG_CTRL) && !cfg_wdata[0])) |-> (match == '0));
endmodule

// File: rtl/bkpt_prio_enc.sv
module bkpt_prio_enc
  import bkpt_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    any   = |req;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = IDX_W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/bkpt_tag_pipe.sv
module bkpt_tag_pipe
  import bkpt_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  bkpt_tag_t        tag_in,
  input  logic             flush,
  input  logic             exec_strobe,
  input  logic             stat_clr,
  output logic             halt_req,
  output logic             stat_valid,
  output logic [IDX_W-1:0] stat_idx
);
  localparam int LAST = STAGES - 1;

  bkpt_tag_t stage_q [STAGES];
  logic      fire;

  assign fire = exec_strobe & ~flush & stage_q[LAST].hit;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= tag_in;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req   <= 1'b0;
      stat_valid <= 1'b0;
      stat_idx   <= '0;
    end else begin
      halt_req <= fire;
      if (fire) begin
        stat_valid <= 1'b1;
        stat_idx   <= stage_q[LAST].idx;
      end else if (stat_clr) begin
        stat_valid <= 1'b0;
      end
    end
  end

  // R6
  flush_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (!stage_q[0].hit && !stage_q[LAST].hit));

  // R5
  halt_exec_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> ($past(exec_strobe) && !$past(flush)));

  // R8
  stat_on_halt_chk: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> stat_valid);
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter bit FULL_CFG    = 1'b1,
  parameter int ADDR_W      = 32,
  parameter int CFG_AW      = 3,
  parameter int PIPE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              exec_strobe,
  input  logic              flush,
  output logic              halt_req,
  output logic              stat_valid,
  output logic [IDX_W-1:0]  stat_idx
);
  localparam int NUM_CMP = cmp_count(FULL_CFG);

  logic [NUM_CMP-1:0] match;
  logic [NUM_CMP-1:0] grant;
  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  bkpt_tag_t          fetch_tag;
  logic               stat_clr;

  bkpt_cmp_bank #(
    .NUM_CMP(NUM_CMP),
    .ADDR_W (ADDR_W),
    .CFG_AW (CFG_AW)
  ) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .fetch_valid(fetch_valid),
    .fetch_addr (fetch_addr),
    .match      (match)
  );

  bkpt_prio_enc #(.N(NUM_CMP)) u_prio (
    .req  (match),
    .any  (hit_any),
    .idx  (hit_idx),
    .grant(grant)
  );

  assign fetch_tag = '{hit: hit_any, idx: hit_idx};
  assign stat_clr  = cfg_we & (cfg_addr == CFG_AW'(REG_STAT)) & cfg_wdata[0];

  bkpt_tag_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .tag_in     (fetch_tag),
    .flush      (flush),
    .exec_strobe(exec_strobe),
    .stat_clr   (stat_clr),
    .halt_req   (halt_req),
    .stat_valid (stat_valid),
    .stat_idx   (stat_idx)
  );

  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (hit_any == (match != '0)));

  // R7
  grant_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> ((match & (grant - 1'b1)) == '0));

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!halt_req && !stat_valid));
endmodule

// File: tb/bkpt_unit_bench.sv
module bkpt_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        exec_strobe = 1'b0;
  logic        flush = 1'b0;
  logic        halt_f, stv_f, halt_r, stv_r;
  logic [1:0]  sti_f, sti_r;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;
  int cyc   = 0;

  logic [27:0] m_addr [4];
  bit          m_en   [4];
  bit          m_gen;

  always #10 clk = ~clk;

  bkpt_unit #(.FULL_CFG(1'b1)) u_bkpt_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .exec_strobe(exec_strobe),
    .flush(flush), .halt_req(halt_f), .stat_valid(stv_f), .stat_idx(sti_f));

  bkpt_unit #(.FULL_CFG(1'b0)) u_bkpt_unit_red (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .exec_strobe(exec_strobe),
    .flush(flush), .halt_req(halt_r), .stat_valid(stv_r), .stat_idx(sti_r));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a < 3'd4) begin
      m_en[a]   = d[0];
      m_addr[a] = d[28:1];
    end else if (a == 3'd4) begin
      m_gen = d[0];
    end
  endtask

  function automatic void model_hit(input logic [31:0] a, input int ncmp,
                                    output bit hit, output int idx);
    hit = 0; idx = 0;
    if (!m_gen || a[31:29] != 3'b000) return;
    for (int i = ncmp - 1; i >= 0; i--)
      if (m_en[i] && m_addr[i] == a[28:1]) begin hit = 1; idx = i; end
  endfunction

  // fl: 0 none, 1 flush in fetch cycle, 2 in gap cycle, 3 in execute cycle
  task automatic run_instr(input string tag, input logic [31:0] a, input bit ex,
                           input int fl, input bit clr_in_exec);
    bit hf, hr;
    int jf, jr;
    model_hit(a, 4, hf, jf);
    model_hit(a, 2, hr, jr);
    if (!ex || fl != 0) begin hf = 0; hr = 0; end
    cfg_write(3'd5, 32'h1);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a; flush = (fl == 1);
    @(negedge clk);
    fetch_valid = 1'b0; flush = (fl == 2);
    @(negedge clk);
    exec_strobe = ex; flush = (fl == 3);
    if (clr_in_exec) begin cfg_we = 1'b1; cfg_addr = 3'd5; cfg_wdata = 32'h1; end
    @(negedge clk);
    exec_strobe = 1'b0; flush = 1'b0; cfg_we = 1'b0;
    check({tag, " halt full"}, {31'b0, halt_f}, {31'b0, hf});
    check({tag, " halt reduced"}, {31'b0, halt_r}, {31'b0, hr});
    check({tag, " R8 status full"}, {31'b0, stv_f}, {31'b0, hf});
    check({tag, " R8 status reduced"}, {31'b0, stv_r}, {31'b0, hr});
    if (hf) check({tag, " R7 index full"}, {30'b0, sti_f}, jf);
    if (hr) check({tag, " R7 index reduced"}, {30'b0, sti_r}, jr);
    @(negedge clk);
    check({tag, " R5 one-cycle pulse"}, {30'b0, halt_f, halt_r}, 32'h0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] addrs [9];
    addrs = '{32'h0000_0100, 32'h0000_0101, 32'h0000_0102, 32'h0000_0200, 32'h1FFF_FFFE,
              32'h2000_0100, 32'hE000_0200, 32'h0000_0000, 32'h0000_0300};
    for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_addr[i] = '0; end
    m_gen = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 halt after reset", {30'b0, halt_f, halt_r}, 32'h0);
    check("R9 status after reset", {30'b0, stv_f, stv_r}, 32'h0);
    run_instr("R9 comparators off", 32'h0, 1, 0, 0);
    m_gen = 1; // model only; hardware global still off
    m_gen = 0;

    // R2 program; R3 global on
    cfg_write(3'd0, 32'h0000_0101);
    cfg_write(3'd1, 32'h0000_0201);
    cfg_write(3'd2, 32'h1FFF_FFFF);
    cfg_write(3'd3, 32'hE000_0201); // high bits ignored, same addr as comparator 1
    run_instr("R3 global off", 32'h100, 1, 0, 0);
    cfg_write(3'd4, 32'h1);

    // R4 R5 R1 sweep over addresses and execute
    for (int i = 0; i < 9; i++)
      for (int e = 0; e < 2; e++)
        run_instr($sformatf("R4 R5 R1 sweep a=%0h ex=%0d", addrs[i], e), addrs[i], e[0], 0, 0);

    // R6 flush at each stage
    for (int f = 1; f < 4; f++)
      run_instr($sformatf("R6 flush stage %0d", f), 32'h100, 1, f, 0);

    // R2 R7 disable comparator 1, comparator 3 takes over
    cfg_write(3'd1, 32'h0000_0200);
    run_instr("R2 R7 cmp1 off", 32'h200, 1, 0, 0);
    cfg_write(3'd0, 32'h0000_0301);
    run_instr("R2 cmp0 moved", 32'h300, 1, 0, 0);
    run_instr("R2 cmp0 old addr", 32'h100, 1, 0, 0);

    // R8 halt wins over clear in the same cycle
    run_instr("R8 clear collides", 32'h300, 1, 0, 1);
    cfg_write(3'd5, 32'h1);
    check("R8 cleared after write", {30'b0, stv_f, stv_r}, 32'h0);

    // R3 global disable
    cfg_write(3'd4, 32'h0);
    run_instr("R3 global disabled", 32'h300, 1, 0, 0);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule